// File: doc/BRIEF.md
# Two-Byte Converter Result Reader

This block runs a 16-bit sampling converter that shares an 8-bit parallel bus with other devices. On a start request it pulls the converter's read/convert line low for a set number of cycles, with chip select asserted, to begin a conversion. It then waits for the converter's busy flag to rise, which marks a completed result. It reads the result as two bytes by steering the byte-select line, high byte first, and hands the joined 16-bit word to the host with a one-cycle valid strobe.

An optional early mode also fetches the previous result while the new conversion is still running. That result is marked stale. The read must finish inside a fixed window after the conversion begins, and the window length is derived from the clock frequency. An early read that would run past the window is abandoned and flagged. If the busy flag never rises, a timeout flag is raised instead. The host can program how many cycles each byte is given to settle before it is sampled.

Top module: `adc_byte_reader`

## Requirements
- R1: The bus is sampled only in cycles where read/convert is high and chip select is low. Outside those cycles the bus contents never reach the result.
- R2: A start request accepted in idle holds read/convert low for exactly START_LOW cycles, with chip select low for all of those cycles. Read/convert then returns high.
- R3: Byte-select is 0 while the upper byte is read and 1 while the lower byte is read. The upper byte is always read first, and the result is {upper, lower}.
- R4: Within each byte read, the bus is sampled in the (settle_i+1)-th cycle after byte-select takes its value.
- R5: After the synchronised busy flag rises, the block reads the new result. It then raises valid_o for exactly one cycle with stale_o low.
- R6: If busy does not rise within BUSY_TIMEOUT cycles of waiting, timeout_o pulses for one cycle and the block returns to idle without raising valid_o.
- R7: In early mode, once a fresh result exists, the previous result is read before the new conversion completes. It is delivered with valid_o and stale_o both high, ahead of the fresh result.
- R8: No stale result is delivered before the first fresh result since reset. An early request made before then yields only the fresh result.
- R9: An early read still unfinished WINDOW_NS of clock time after read/convert falls is abandoned. abort_o pulses, no stale word is delivered, and the block goes on to read the fresh result.
- R10: During reset and right after it, chip select and read/convert are high, byte-select is low, and valid_o, timeout_o and abort_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a conversion (accepted in idle) |
| early_i | input | 1 | Also read the previous result during the conversion |
| settle_i | input | SETTLE_W | Extra settle cycles per byte before sampling |
| adc_busy_i | input | 1 | Converter busy flag (high = result ready) |
| adc_bus_i | input | BYTE_W | Converter parallel data bus |
| adc_rc_o | output | 1 | Read/convert line (low starts a conversion) |
| adc_cs_n_o | output | 1 | Converter chip select, active low |
| adc_byte_o | output | 1 | Byte select (0 upper, 1 lower) |
| result_o | output | 2*BYTE_W | Joined result word |
| valid_o | output | 1 | One-cycle strobe for result_o |
| stale_o | output | 1 | Result belongs to the previous conversion |
| timeout_o | output | 1 | Busy never rose |
| abort_o | output | 1 | Early read abandoned at window end |

## Verification
A wrong state register shows up at the pins within a cycle or two: chip select or byte-select moves in the wrong order, or read/convert stays low for the wrong number of cycles. A wrong capture shows up as a result word that holds the bench's idle-bus filler 0xEE or has its bytes swapped. That mismatch is visible at the next valid strobe. Faults in the window or stale-result tracking appear a whole conversion later, as a missing or extra stale word or a missing abort pulse. The scoreboard catches these because it expects an exact sequence of words per conversion.

// File: rtl/adc_rd_pkg.sv
// Shared types for the two-byte converter reader.
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT_BUSY,
        ST_READ_HI,
        ST_READ_LO,
        ST_DONE
    } rd_state_t;
endpackage

// File: rtl/adc_rd_busy_sync.sv
// Synchronises the converter busy flag and keeps a sticky "rose" flag.
// Assumes busy idles high; sync stages reset high so no false edge appears.
module adc_rd_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic clear_i,
    output logic rose_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              rose_q;

    // Shift the flag in, remember its last value, latch a rising edge until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
            rose_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], busy_i};
            last_q <= sync_q[STAGES-1];
            if (clear_i)
                rose_q <= 1'b0;
            else if (sync_q[STAGES-1] && !last_q)
                rose_q <= 1'b1;
        end
    end

    assign rose_o = rose_q;
endmodule

// File: rtl/adc_rd_window.sv
// Counts cycles since a conversion began and reports when the early-read
// window has run out. Assumes restart_i pulses once per conversion.
module adc_rd_window #(
    parameter int LIMIT = 2400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic expired_o
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt_q;

    // Saturating cycle counter, cleared at each conversion start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= W'(LIMIT);
        else if (restart_i)
            cnt_q <= '0;
        else if (cnt_q != W'(LIMIT))
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q == W'(LIMIT));
endmodule

// File: rtl/adc_rd_fsm.sv
// Sequencer: start pulse, busy wait with timeout, two byte reads with settle,
// optional early read of the previous result. Pin levels decode the state.
module adc_rd_fsm
    import adc_rd_pkg::*;
#(
    parameter int START_LOW    = 4,
    parameter int BUSY_TIMEOUT = 65535,
    parameter int SETTLE_W     = 4,
    parameter int BYTE_W       = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                early_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                busy_rose_i,
    input  logic                win_expired_i,
    input  logic [BYTE_W-1:0]   bus_i,
    output logic                conv_start_o,
    output logic                rc_o,
    output logic                cs_n_o,
    output logic                byte_o,
    output logic [2*BYTE_W-1:0] result_o,
    output logic                valid_o,
    output logic                stale_o,
    output logic                timeout_o,
    output logic                abort_o
);
    localparam int CW_T  = $clog2(BUSY_TIMEOUT + 1);
    localparam int CW_S  = $clog2(START_LOW + 1);
    localparam int CW_A  = (CW_T > CW_S) ? CW_T : CW_S;
    localparam int CW    = (CW_A > SETTLE_W) ? CW_A : SETTLE_W;

    rd_state_t           state_q;
    logic [CW-1:0]       cnt_q;
    logic                early_q;
    logic                have_q;
    logic [BYTE_W-1:0]   hi_q;
    logic [2*BYTE_W-1:0] result_q;
    logic                timeout_q;
    logic                abort_q;
    logic                settled;

    assign settled      = (cnt_q == CW'(settle_i));
    assign conv_start_o = (state_q == ST_IDLE) && start_i;

    // Main sequencer: state, shared counter, byte capture and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            early_q   <= 1'b0;
            have_q    <= 1'b0;
            hi_q      <= '0;
            result_q  <= '0;
            timeout_q <= 1'b0;
            abort_q   <= 1'b0;
        end else begin
            timeout_q <= 1'b0;
            abort_q   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_START;
                        cnt_q   <= '0;
                        early_q <= early_i && have_q;
                    end
                end
                ST_START: begin
                    if (cnt_q == CW'(START_LOW - 1)) begin
                        cnt_q   <= '0;
                        state_q <= early_q ? ST_READ_HI : ST_WAIT_BUSY;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WAIT_BUSY: begin
                    if (busy_rose_i) begin
                        state_q <= ST_READ_HI;
                        cnt_q   <= '0;
                    end else if (cnt_q == CW'(BUSY_TIMEOUT - 1)) begin
                        state_q   <= ST_IDLE;
                        cnt_q     <= '0;
                        timeout_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_READ_HI, ST_READ_LO: begin
                    if (early_q && win_expired_i) begin
                        state_q <= ST_WAIT_BUSY;
                        cnt_q   <= '0;
                        early_q <= 1'b0;
                        abort_q <= 1'b1;
                    end else if (settled) begin
                        cnt_q <= '0;
                        if (state_q == ST_READ_HI) begin
                            hi_q    <= bus_i;
                            state_q <= ST_READ_LO;
                        end else begin
                            result_q <= {hi_q, bus_i};
                            state_q  <= ST_DONE;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DONE: begin
                    cnt_q <= '0;
                    if (early_q) begin
                        early_q <= 1'b0;
                        state_q <= ST_WAIT_BUSY;
                    end else begin
                        have_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Pin and strobe decode from the registered state.
    always_comb begin
        rc_o    = (state_q != ST_START);
        cs_n_o  = !((state_q == ST_START) || (state_q == ST_READ_HI) ||
                    (state_q == ST_READ_LO));
        byte_o  = (state_q == ST_READ_LO);
        valid_o = (state_q == ST_DONE);
        stale_o = (state_q == ST_DONE) && early_q;
    end

    assign result_o  = result_q;
    assign timeout_o = timeout_q;
    assign abort_o   = abort_q;
endmodule

// File: rtl/adc_byte_reader.sv
// Top: two-byte converter result reader. Ties busy sync, window timer and
// sequencer. Assumes the converter is strapped for parallel readout.
module adc_byte_reader #(
    parameter int CLK_MHZ      = 200,
    parameter int WINDOW_NS    = 12000,
    parameter int START_LOW    = 4,
    parameter int BUSY_TIMEOUT = 65535,
    parameter int SETTLE_W     = 4,
    parameter int SYNC_STAGES  = 2,
    parameter int BYTE_W       = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                early_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                adc_busy_i,
    input  logic [BYTE_W-1:0]   adc_bus_i,
    output logic                adc_rc_o,
    output logic                adc_cs_n_o,
    output logic                adc_byte_o,
    output logic [2*BYTE_W-1:0] result_o,
    output logic                valid_o,
    output logic                stale_o,
    output logic                timeout_o,
    output logic                abort_o
);
    localparam int WIN_CYCLES = CLK_MHZ * WINDOW_NS / 1000;

    logic conv_start;
    logic busy_rose;
    logic win_expired;

    adc_rd_busy_sync #(.STAGES(SYNC_STAGES)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_i  (adc_busy_i),
        .clear_i (conv_start),
        .rose_o  (busy_rose)
    );

    adc_rd_window #(.LIMIT(WIN_CYCLES)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (conv_start),
        .expired_o (win_expired)
    );

    adc_rd_fsm #(
        .START_LOW    (START_LOW),
        .BUSY_TIMEOUT (BUSY_TIMEOUT),
        .SETTLE_W     (SETTLE_W),
        .BYTE_W       (BYTE_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .early_i       (early_i),
        .settle_i      (settle_i),
        .busy_rose_i   (busy_rose),
        .win_expired_i (win_expired),
        .bus_i         (adc_bus_i),
        .conv_start_o  (conv_start),
        .rc_o          (adc_rc_o),
        .cs_n_o        (adc_cs_n_o),
        .byte_o        (adc_byte_o),
        .result_o      (result_o),
        .valid_o       (valid_o),
        .stale_o       (stale_o),
        .timeout_o     (timeout_o),
        .abort_o       (abort_o)
    );
endmodule

// File: rtl/adc_rd_checker.sv
// Protocol checker bound to the reader; watches pins only.
module adc_rd_checker #(
    parameter int START_LOW  = 4,
    parameter int WIN_CYCLES = 2400
) (
    input logic clk,
    input logic rst_n,
    input logic adc_busy_i,
    input logic adc_rc_o,
    input logic adc_cs_n_o,
    input logic adc_byte_o,
    input logic valid_o,
    input logic stale_o,
    input logic timeout_o
);
    localparam int LW = $clog2(START_LOW + 2);
    localparam int WW = $clog2(WIN_CYCLES + 8);

    logic [LW-1:0] low_cnt;
    logic [WW-1:0] win_cnt;
    logic          rc_q;
    logic          fresh_seen;

    // Track start-pulse width, time since rc fell, and first fresh result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt    <= '0;
            win_cnt    <= '0;
            rc_q       <= 1'b1;
            fresh_seen <= 1'b0;
        end else begin
            rc_q <= adc_rc_o;
            if (!adc_rc_o)
                low_cnt <= (low_cnt == LW'(START_LOW + 1)) ? low_cnt : low_cnt + 1'b1;
            else
                low_cnt <= '0;
            if (rc_q && !adc_rc_o)
                win_cnt <= '0;
            else if (win_cnt != WW'(WIN_CYCLES + 7))
                win_cnt <= win_cnt + 1'b1;
            if (valid_o && !stale_o)
                fresh_seen <= 1'b1;
        end
    end

    a_r2_start_width: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_rc_o && !rc_q) |-> (low_cnt == LW'(START_LOW)));

    a_r2_cs_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_rc_o |-> !adc_cs_n_o);

    a_r3_low_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_byte_o) |-> $past(!adc_cs_n_o && adc_rc_o && !adc_byte_o));

    a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    a_r6_timeout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (!valid_o && adc_cs_n_o));

    a_r8_stale_after_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && stale_o) |-> fresh_seen);

    a_r9_window_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!adc_cs_n_o && adc_rc_o && !adc_busy_i) |-> (win_cnt <= WW'(WIN_CYCLES + 2)));
endmodule

bind adc_byte_reader adc_rd_checker #(
    .START_LOW  (START_LOW),
    .WIN_CYCLES (WIN_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .adc_busy_i (adc_busy_i),
    .adc_rc_o   (adc_rc_o),
    .adc_cs_n_o (adc_cs_n_o),
    .adc_byte_o (adc_byte_o),
    .valid_o    (valid_o),
    .stale_o    (stale_o),
    .timeout_o  (timeout_o)
);

// File: tb/adc_byte_reader_tb.sv
// Scoreboard bench with a behavioural converter model on the pins.
module adc_byte_reader_tb;
    localparam int START_LOW = 3;
    localparam int TMO       = 200;
    localparam int CONV      = 60;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        early_i = 1'b0;
    logic [3:0]  settle_i = 4'd0;
    logic        adc_busy;
    logic [7:0]  adc_bus;
    logic        adc_rc, adc_cs_n, adc_byte;
    logic [15:0] result;
    logic        valid, stale, timeout, abort_p;

    logic [15:0] out_reg;
    logic [15:0] pending = 16'h0000;
    logic        hang = 1'b0;
    int          conv_left;

    int checks = 0;
    int errors = 0;
    int fresh_cnt = 0;
    int tmo_cnt = 0;
    int abort_cnt = 0;
    int low_cnt = 0;
    logic [16:0] exp_q[$];

    always #2.5 clk = ~clk;

    adc_byte_reader #(
        .CLK_MHZ(200), .WINDOW_NS(100), .START_LOW(START_LOW),
        .BUSY_TIMEOUT(TMO), .SETTLE_W(4), .SYNC_STAGES(2), .BYTE_W(8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .early_i(early_i),
        .settle_i(settle_i), .adc_busy_i(adc_busy), .adc_bus_i(adc_bus),
        .adc_rc_o(adc_rc), .adc_cs_n_o(adc_cs_n), .adc_byte_o(adc_byte),
        .result_o(result), .valid_o(valid), .stale_o(stale),
        .timeout_o(timeout), .abort_o(abort_p)
    );

    // Converter model: bus drives only with rc high and cs low (R1), else filler.
    assign adc_bus = (adc_rc && !adc_cs_n) ? (adc_byte ? out_reg[7:0] : out_reg[15:8]) : 8'hEE;

    always @(posedge clk) begin
        if (!rst_n) begin
            adc_busy  <= 1'b1;
            conv_left <= 0;
            out_reg   <= 16'hDEAD;
        end else if (adc_busy && !adc_rc && !adc_cs_n) begin
            adc_busy  <= 1'b0;
            conv_left <= CONV;
        end else if (!adc_busy && !hang) begin
            if (conv_left == 0) begin
                out_reg  <= pending;
                adc_busy <= 1'b1;
            end else begin
                conv_left <= conv_left - 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard pops on valid, counts pulses, measures start width.
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid) begin
                if (exp_q.size() == 0) begin
                    check("R5/R8 unexpected word", {stale, result}, 32'h0);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    check("R3/R5/R7 word", {15'd0, stale, result}, {15'd0, e});
                end
                if (!stale) fresh_cnt++;
            end
            if (timeout) tmo_cnt++;
            if (abort_p) abort_cnt++;
            if (!adc_rc) begin
                low_cnt++;
                if (adc_cs_n) check("R2 cs low during start", 1, 0);
            end else if (low_cnt != 0) begin
                check("R2 start width", low_cnt, START_LOW);
                low_cnt = 0;
            end
        end
    end

    task automatic run_conv(input logic [15:0] val, input logic early, input logic [3:0] settle,
                            input logic exp_stale, input logic [15:0] prev, input logic hang_it);
        int f0, t0;
        if (exp_stale) exp_q.push_back({1'b1, prev});
        if (!hang_it)  exp_q.push_back({1'b0, val});
        pending  = val;
        hang     = hang_it;
        early_i  = early;
        settle_i = settle;
        f0 = fresh_cnt;
        t0 = tmo_cnt;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (fresh_cnt != f0 || tmo_cnt != t0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 cs_n", adc_cs_n, 1);
        check("R10 rc", adc_rc, 1);
        check("R10 byte", adc_byte, 0);
        check("R10 valid", valid, 0);
        check("R10 timeout", timeout, 0);
        check("R10 abort", abort_p, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R8: early request with no fresh result yet gives only the fresh word
        run_conv(16'h1234, 1'b1, 4'd1, 1'b0, 16'h0, 1'b0);
        check("R8 queue drained", exp_q.size(), 0);
        // R3 R5: normal read, no settle
        run_conv(16'hBEEF, 1'b0, 4'd0, 1'b0, 16'h0, 1'b0);
        // R7: early read returns previous word stale, then fresh
        run_conv(16'h00FF, 1'b1, 4'd2, 1'b1, 16'hBEEF, 1'b0);
        check("R7 no abort in window", abort_cnt, 0);
        // R9 R4: long settle overruns the window, early read abandoned
        run_conv(16'h8001, 1'b1, 4'd15, 1'b0, 16'h0, 1'b0);
        check("R9 abort pulse", abort_cnt, 1);
        // R6: busy never rises
        run_conv(16'h5555, 1'b0, 4'd0, 1'b0, 16'h0, 1'b1);
        check("R6 timeout pulse", tmo_cnt, 1);
        hang = 1'b0;
        repeat (100) @(negedge clk);
        // R4 R1: settle 3 normal read after recovery
        run_conv(16'hA5C3, 1'b0, 4'd3, 1'b0, 16'h0, 1'b0);
        check("R6 no word from timed-out conversion", exp_q.size(), 0);
        check("R5 fresh count", fresh_cnt, 5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule